// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a virtual address into a physical address by reading translation tables kept in external memory. A request carries a 4-bit context number, a 32-bit virtual address and two access attributes: write or read, and user or supervisor mode. The walker first reads the context table, whose base is held in a configuration register. It then follows pointer words through up to three further table levels until it finds a page entry. It checks the page's permission code against the access. It then marks the entry as referenced, and also as modified on a write, and stores the entry back when those bits change. It returns either a physical address with a cacheable flag, or a fault code.

All table reads and the write-back go through one memory port with a valid/ready handshake and at most one access in flight. A page entry found before the last level maps a large page: 16 MB at level 1 and 256 KB at level 2. For a large page, the low virtual address bits pass straight through to the physical address.

Top module: `pt_walker`

## Requirements
- R1: The two least significant bits of a table word give its kind: 0 invalid, 1 pointer to the next table, 2 page entry, 3 reserved. The next table starts at byte address (word with bits 1:0 cleared) << 4. An entry's byte address is the table start plus four times the index.
- R2: The context table starts at (configuration word with bits 1:0 cleared) << 4. The configuration word is loaded by `cfg_we`, reads 0 after reset, and is indexed by `req_ctx`. Level 1 is indexed by VA[31:24], level 2 by VA[23:18] and level 3 by VA[17:12].
- R3: A page entry holds the physical page number in bits 31:8, cacheable in bit 7, modified in bit 6, referenced in bit 5 and a permission code in bits 4:2. A level-3 page gives the address {page number, VA[11:0]}, and `rsp_cacheable` equals bit 7.
- R4: A page entry at level 1 gives {page number[23:12], VA[23:0]}. A page entry at level 2 gives {page number[23:6], VA[17:0]}.
- R5: A kind fault ends the walk with `rsp_fault` equal to 1 + level, where the context table is level 0. A kind fault is an invalid or reserved word at any level, a page entry in the context table, or a pointer at level 3. A successful walk reports 0.
- R6: The permission codes 0..7 mean, for user/supervisor: R/R, RW/RW, RX/RX, RWX/RWX, X/X, R/RW, none/RX, none/RWX. A user access to a code above 5 faults. A write faults unless the code grants write to the current mode: codes 1 and 3 for user, codes 1, 3, 5 and 7 for supervisor. A protection fault gives `rsp_fault` = 5.
- R7: After the checks pass, the entry is updated with bit 5 set, and with bit 6 also set on a write. The updated entry is written once to the address it was read from. No write takes place when neither bit changes, or when the walk faults.
- R8: `mem_valid` stays high, with `mem_addr`, `mem_we` and `mem_wdata` stable, until `mem_ready`. Read data is taken in the cycle of the handshake. No access is issued while the walker is idle.
- R9: `rsp_valid` is a one-cycle pulse that ends each accepted request. `req_ready` is high only when the walker is idle. On a fault `rsp_pa` and `rsp_cacheable` are 0.
- R10: After reset `req_ready` is 1 and both `rsp_valid` and `mem_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the context table base word |
| cfg_base | input | 32 | Context table base word |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_ctx | input | 4 | Context number |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 3 | 0 ok, 1..4 kind fault at level 0..3, 5 protection |
| rsp_pa | output | 36 | Physical address |
| rsp_cacheable | output | 1 | Page is cacheable |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | Access is a write-back |
| mem_addr | output | 36 | Byte address of the table word |
| mem_wdata | output | 32 | Updated page entry |
| mem_rdata | input | 32 | Table word, valid at the handshake |

## Verification
The bench targets the permission matrix at its edges. These are code 5, where user reads but may not write; codes 6 and 7, which lock out user; and code 0, which denies all writes. A design that swapped the mode columns or compared against the wrong threshold would let a forbidden access through or fault a legal one. The bench also checks that write-back is skipped when the referenced and modified bits are already set, and counts memory writes: a design that always wrote back would show an extra write. Large pages at levels 1 and 2, a pointer found at level 3, and a page entry found in the context table check that the address splicing and the fault level follow the level reached. The memory stalls on an irregular pattern and the context base is moved, to catch a walker that samples data outside the handshake or forgets to clear the kind bits of a pointer.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
    localparam int WORD_W  = 32;
    localparam int VA_W    = 32;
    localparam int PA_W    = WORD_W + 4;
    localparam int CTX_W   = 4;
    localparam int PPN_W   = 24;
    localparam int OFF_W   = 12;
    localparam int L1_SPAN = 24;   // low VA bits kept by a level-1 page
    localparam int L2_SPAN = 18;   // low VA bits kept by a level-2 page
    localparam int LVL_W   = 2;
    localparam int IDX_W   = 8;

    typedef enum logic [1:0] {
        ET_INVALID = 2'd0,
        ET_PTR     = 2'd1,
        ET_PAGE    = 2'd2,
        ET_RSVD    = 2'd3
    } ent_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_CTX  = 3'd1,
        FLT_LV1  = 3'd2,
        FLT_LV2  = 3'd3,
        FLT_LV3  = 3'd4,
        FLT_PROT = 3'd5
    } fault_e;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             cacheable;
        logic             modified;
        logic             referenced;
        logic [2:0]       perm;
        ent_kind_e        kind;
    } page_ent_t;

    typedef enum logic [1:0] {
        S_IDLE, S_READ, S_WBACK, S_DONE
    } walk_state_e;

    // Start of the table a pointer word refers to.
    function automatic logic [PA_W-1:0] table_start(input logic [WORD_W-1:0] w);
        return {w[WORD_W-1:2], 2'b00, 4'b0000};
    endfunction

    // Permission check against the 3-bit access code.
    function automatic logic access_ok(input logic [2:0] perm,
                                       input logic user, input logic write);
        logic ok;
        ok = 1'b1;
        if (user && perm > 3'd5)
            ok = 1'b0;
        if (write) begin
            if (user) ok = ok && perm[0] && !perm[2];
            else      ok = ok && perm[0];
        end
        return ok;
    endfunction
endpackage

// File: rtl/pt_walker_addr.sv
module pt_walker_addr
    import pt_walker_pkg::*;
(
    input  logic [PA_W-1:0]    tbl_start,
    input  logic [LVL_W-1:0]   lvl,
    input  logic [CTX_W-1:0]   ctx,
    input  logic [VA_W-1:OFF_W] va_hi,
    output logic [PA_W-1:0]    ent_addr
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        unique case (lvl)
            2'd0:    idx = IDX_W'(ctx);
            2'd1:    idx = va_hi[31:24];
            2'd2:    idx = IDX_W'(va_hi[23:18]);
            default: idx = IDX_W'(va_hi[17:12]);
        endcase
    end

    assign ent_addr = tbl_start + PA_W'({idx, 2'b00});
endmodule

// File: rtl/pt_walker_eval.sv
module pt_walker_eval
    import pt_walker_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  logic [LVL_W-1:0]   lvl,
    input  logic [L1_SPAN-1:0] va_low,
    input  logic               user,
    input  logic               write,
    output ent_kind_e          kind,
    output logic               allowed,
    output logic               need_wb,
    output logic [WORD_W-1:0]  upd_word,
    output logic [PA_W-1:0]    pa,
    output logic               cacheable
);
    page_ent_t ent, upd;

    always_comb begin
        ent            = page_ent_t'(word);
        upd            = ent;
        upd.referenced = 1'b1;
        if (write)
            upd.modified = 1'b1;
    end

    assign kind      = ent.kind;
    assign allowed   = access_ok(ent.perm, user, write);
    assign need_wb   = (upd != ent);
    assign upd_word  = WORD_W'(upd);
    assign cacheable = ent.cacheable;

    always_comb begin
        unique case (lvl)
            2'd1:    pa = {ent.ppn[PPN_W-1:L1_SPAN-OFF_W], va_low[L1_SPAN-1:0]};
            2'd2:    pa = {ent.ppn[PPN_W-1:L2_SPAN-OFF_W], va_low[L2_SPAN-1:0]};
            default: pa = {ent.ppn, va_low[OFF_W-1:0]};
        endcase
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WORD_W-1:0] cfg_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_cacheable,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(3);

    walk_state_e       state;
    logic [WORD_W-1:0] base_q;
    logic [PA_W-1:0]   tbl_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [CTX_W-1:0]  ctx_q;
    logic [VA_W-1:0]   va_q;
    logic              wr_q, user_q;
    logic [WORD_W-1:0] wb_q;
    fault_e            flt_q;
    logic [PA_W-1:0]   pa_q;
    logic              cach_q;

    ent_kind_e         kind;
    logic              allowed, need_wb, pg_cach;
    logic [WORD_W-1:0] upd_word;
    logic [PA_W-1:0]   pg_pa, ent_addr;
    fault_e            flt_kind;

    pt_walker_addr u_addr (
        .tbl_start (tbl_q),
        .lvl       (lvl_q),
        .ctx       (ctx_q),
        .va_hi     (va_q[VA_W-1:OFF_W]),
        .ent_addr  (ent_addr)
    );

    pt_walker_eval u_eval (
        .word      (mem_rdata),
        .lvl       (lvl_q),
        .va_low    (va_q[L1_SPAN-1:0]),
        .user      (user_q),
        .write     (wr_q),
        .kind      (kind),
        .allowed   (allowed),
        .need_wb   (need_wb),
        .upd_word  (upd_word),
        .pa        (pg_pa),
        .cacheable (pg_cach)
    );

    assign flt_kind = fault_e'({1'b0, lvl_q} + 3'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            base_q <= '0;
            tbl_q  <= '0;
            lvl_q  <= '0;
            ctx_q  <= '0;
            va_q   <= '0;
            wr_q   <= 1'b0;
            user_q <= 1'b0;
            wb_q   <= '0;
            flt_q  <= FLT_NONE;
            pa_q   <= '0;
            cach_q <= 1'b0;
        end else begin
            if (cfg_we)
                base_q <= cfg_base;
            unique case (state)
                S_IDLE: if (req_valid) begin
                    ctx_q  <= req_ctx;
                    va_q   <= req_va;
                    wr_q   <= req_write;
                    user_q <= req_user;
                    tbl_q  <= table_start(base_q);
                    lvl_q  <= '0;
                    state  <= S_READ;
                end
                S_READ: if (mem_ready) begin
                    if (kind == ET_PTR && lvl_q != LAST_LVL) begin
                        tbl_q <= table_start(mem_rdata);
                        lvl_q <= lvl_q + 1'b1;
                    end else if (kind == ET_PAGE && lvl_q != '0) begin
                        if (allowed) begin
                            flt_q  <= FLT_NONE;
                            pa_q   <= pg_pa;
                            cach_q <= pg_cach;
                            wb_q   <= upd_word;
                            state  <= need_wb ? S_WBACK : S_DONE;
                        end else begin
                            flt_q  <= FLT_PROT;
                            pa_q   <= '0;
                            cach_q <= 1'b0;
                            state  <= S_DONE;
                        end
                    end else begin
                        flt_q  <= flt_kind;
                        pa_q   <= '0;
                        cach_q <= 1'b0;
                        state  <= S_DONE;
                    end
                end
                S_WBACK: if (mem_ready)
                    state <= S_DONE;
                default:
                    state <= S_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == S_IDLE);
    assign rsp_valid     = (state == S_DONE);
    assign rsp_fault     = flt_q;
    assign rsp_pa        = pa_q;
    assign rsp_cacheable = cach_q;
    assign mem_valid     = (state == S_READ) || (state == S_WBACK);
    assign mem_we        = (state == S_WBACK);
    assign mem_addr      = ent_addr;
    assign mem_wdata     = wb_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
    import pt_walker_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [2:0]        rsp_fault,
    input logic [PA_W-1:0]   rsp_pa,
    input logic              rsp_cacheable,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [PA_W-1:0]   mem_addr,
    input logic [WORD_W-1:0] mem_wdata
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_valid); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R9
    AST_RSP_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready); // R9
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault != 3'd0 |-> rsp_pa == '0 && !rsp_cacheable); // R9
    AST_FAULT_RANGE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_fault <= 3'd5); // R5
    AST_WB_MARKED: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_we |-> mem_wdata[5] && mem_wdata[1:0] == 2'b10); // R7
endmodule

bind pt_walker pt_walker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_pa        (rsp_pa),
    .rsp_cacheable (rsp_cacheable),
    .mem_valid     (mem_valid),
    .mem_ready     (mem_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_base = '0;
    logic        req_valid = 1'b0, req_ready;
    logic [3:0]  req_ctx = '0;
    logic [31:0] req_va = '0;
    logic        req_write = 1'b0, req_user = 1'b0;
    logic        rsp_valid, rsp_cacheable;
    logic [2:0]  rsp_fault;
    logic [35:0] rsp_pa;
    logic        mem_valid, mem_we;
    logic        mem_ready = 1'b0;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    pt_walker u_dut (.*);

    // Memory model: 4 KB of words, tables placed in the low area.
    logic [31:0] mem [1024];
    int          wr_total = 0;
    logic        first_pend = 1'b0;
    logic [35:0] first_addr = '0;
    int          rdy_cnt = 0;

    function automatic logic [31:0] init_word(input int i);
        case (i * 4)
            32'h000: return 32'h00000041; // ctx0 -> level-1 table at 0x400
            32'h004: return 32'h00000000; // ctx1 invalid
            32'h008: return 32'h00000003; // ctx2 reserved
            32'h00C: return 32'h00001202; // ctx3 page entry
            32'h100: return 32'h00000041; // alternate context table
            32'h400: return 32'h00000081; // L1[0] -> level-2 table at 0x800
            32'h404: return 32'h123456EE; // L1[1] 16 MB page, RWX, C R M set
            32'h408: return 32'h00000000;
            32'h40C: return 32'h00000003;
            32'h800: return 32'h000000A1; // L2[0] -> level-3 table at 0xA00
            32'h804: return 32'h0ABCDE06; // L2[1] 256 KB page, RW
            32'h808: return 32'h00000000;
            32'hA00: return 32'h00000011; // pointer at last level
            32'hA04: return 32'h00000000;
            32'hA08: return 32'h00077796; // code 5, C
            32'hA0C: return 32'h0FEDCB3E; // code 7, R
            32'hA10: return 32'h00ABC0E2; // code 0, C R M
            32'hA14: return 32'h0001002E; // code 3, R
            default: return 32'h0;
        endcase
    endfunction

    assign mem_rdata = mem[mem_addr[11:2]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 1024; i++) mem[i] <= init_word(i);
        end else if (mem_valid && mem_ready && mem_we) begin
            mem[mem_addr[11:2]] <= mem_wdata;
            wr_total <= wr_total + 1;
        end
        if (req_valid && req_ready)
            first_pend <= 1'b1;
        else if (mem_valid && mem_ready && first_pend) begin
            first_addr <= mem_addr;
            first_pend <= 1'b0;
        end
    end

    always @(negedge clk) begin
        rdy_cnt   <= rdy_cnt + 1;
        mem_ready <= (rdy_cnt % 3) != 0;
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [3:0]  ctx;
        logic [31:0] va;
        logic        wr;
        logic        user;
        logic [2:0]  flt;
        logic [35:0] pa;
        logic        cach;
        logic        wb;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 32'h00002ABC, 1'b0, 1'b1, 3'd0, 36'h000777ABC, 1'b1, 1'b1, 4'd3},  // R3 R7 user read code 5
        '{4'd0, 32'h00002ABC, 1'b1, 1'b1, 3'd5, 36'h0,         1'b0, 1'b0, 4'd6},  // R6 user write code 5
        '{4'd0, 32'h00002010, 1'b1, 1'b0, 3'd0, 36'h000777010, 1'b1, 1'b1, 4'd6},  // R6 sup write code 5
        '{4'd0, 32'h00003000, 1'b0, 1'b1, 3'd5, 36'h0,         1'b0, 1'b0, 4'd6},  // R6 user code 7
        '{4'd0, 32'h00003FFF, 1'b1, 1'b0, 3'd0, 36'h0FEDCBFFF, 1'b0, 1'b1, 4'd6},  // R6 sup write code 7
        '{4'd0, 32'h00004123, 1'b1, 1'b0, 3'd5, 36'h0,         1'b0, 1'b0, 4'd6},  // R6 write code 0
        '{4'd0, 32'h00004123, 1'b0, 1'b1, 3'd0, 36'h00ABC0123, 1'b1, 1'b0, 4'd7},  // R7 bits already set
        '{4'd0, 32'h00005555, 1'b1, 1'b1, 3'd0, 36'h000100555, 1'b0, 1'b1, 4'd7},  // R7 sets modified
        '{4'd0, 32'h00000000, 1'b0, 1'b0, 3'd4, 36'h0,         1'b0, 1'b0, 4'd5},  // R5 pointer at level 3
        '{4'd0, 32'h00001000, 1'b0, 1'b0, 3'd4, 36'h0,         1'b0, 1'b0, 4'd5},  // R5 invalid level 3
        '{4'd0, 32'h00080000, 1'b0, 1'b0, 3'd3, 36'h0,         1'b0, 1'b0, 4'd5},  // R5 invalid level 2
        '{4'd0, 32'h00052345, 1'b0, 1'b0, 3'd0, 36'h0ABCD2345, 1'b0, 1'b1, 4'd4},  // R4 256 KB page
        '{4'd0, 32'h01ABCDEF, 1'b1, 1'b1, 3'd0, 36'h123ABCDEF, 1'b1, 1'b0, 4'd4},  // R4 16 MB page
        '{4'd0, 32'h02000000, 1'b0, 1'b0, 3'd2, 36'h0,         1'b0, 1'b0, 4'd5},  // R5 invalid level 1
        '{4'd0, 32'h03000000, 1'b0, 1'b0, 3'd2, 36'h0,         1'b0, 1'b0, 4'd1},  // R1 reserved kind
        '{4'd1, 32'h00002000, 1'b0, 1'b0, 3'd1, 36'h0,         1'b0, 1'b0, 4'd5},  // R5 invalid context
        '{4'd2, 32'h00002000, 1'b0, 1'b0, 3'd1, 36'h0,         1'b0, 1'b0, 4'd1},  // R1 reserved context
        '{4'd3, 32'h00002000, 1'b0, 1'b0, 3'd1, 36'h0,         1'b0, 1'b0, 4'd5}   // R5 page in context table
    };

    logic [2:0]  got_flt;
    logic [35:0] got_pa;
    logic        got_c, got_done;
    int          got_wb;

    task automatic walk(input logic [3:0] ctx, input logic [31:0] va,
                        input logic wr, input logic user);
        int wr_before, n;
        @(negedge clk);
        req_valid = 1'b1; req_ctx = ctx; req_va = va; req_write = wr; req_user = user;
        wr_before = wr_total;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 200) begin
            @(negedge clk);
            n++;
        end
        got_done = rsp_valid;
        got_flt  = rsp_fault;
        got_pa   = rsp_pa;
        got_c    = rsp_cacheable;
        got_wb   = wr_total - wr_before;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL R9 watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        string tag;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10", "req_ready", 64'(req_ready), 64'd1);
        chk("R10", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R10", "mem_valid", 64'(mem_valid), 64'd0);

        for (int v = 0; v < NV; v++) begin
            tag = $sformatf("R%0d v%0d", VECS[v].rq, v);
            walk(VECS[v].ctx, VECS[v].va, VECS[v].wr, VECS[v].user);
            chk("R9", "response seen", 64'(got_done), 64'd1);
            chk(tag, "fault", 64'(got_flt), 64'(VECS[v].flt));
            chk(tag, "pa", 64'(got_pa), 64'(VECS[v].pa));
            chk(tag, "cacheable", 64'(got_c), 64'(VECS[v].cach));
            chk(tag, "writes", 64'(got_wb), 64'(VECS[v].wb));
        end

        // R7: stored entries after the walks above
        chk("R7", "entry A08", 64'(mem[32'hA08 >> 2]), 64'h000777F6);
        chk("R7", "entry A0C", 64'(mem[32'hA0C >> 2]), 64'h0FEDCB7E);
        chk("R7", "entry A10", 64'(mem[32'hA10 >> 2]), 64'h00ABC0E2);
        chk("R7", "entry A14", 64'(mem[32'hA14 >> 2]), 64'h0001006E);
        chk("R7", "entry 804", 64'(mem[32'h804 >> 2]), 64'h0ABCDE26);
        chk("R7", "entry 404", 64'(mem[32'h404 >> 2]), 64'h123456EE);

        // R2: context index scales to word address
        walk(4'd3, 32'h00002000, 1'b0, 1'b0);
        chk("R2", "ctx3 first address", 64'(first_addr), 64'h00C);

        // R2: move the context table base through the config word
        @(negedge clk);
        cfg_we = 1'b1; cfg_base = 32'h00000010;
        @(negedge clk);
        cfg_we = 1'b0;
        walk(4'd0, 32'h00004123, 1'b0, 1'b1);
        chk("R2", "moved base first address", 64'(first_addr), 64'h100);
        chk("R2", "moved base pa", 64'(got_pa), 64'h00ABC0123);
        chk("R2", "moved base fault", 64'(got_flt), 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule